// File: doc/BRIEF.md
# UART Status Flags and Interrupt Requests

This block is the processor-side status and interrupt logic of a simple serial port. It keeps one 8-bit status/control byte. The byte holds three event flags: receive full, receive error and transmit empty. It also holds two interrupt enables and a pair of ninth-bit/parity bits. Separate receive and transmit shift engines report events to it as single-cycle pulses. The engines sit outside this block. A pulse says that a frame was received (qualified by overrun and framing error), or that the transmitter took the buffered byte. The block holds the receive data register and hands bytes from the processor to the transmitter.

Software clears a flag with two accesses in order. First it reads the status byte. Then it accesses the matching data register. Each flag keeps its own armed bit for this. The status read copies the flag into the armed bit. The next data access clears the flag only if the armed bit is set, and always drops the armed bit. A frame with an error sets the error flag and leaves the receive data register as it was. Bit 1 of the status byte changes meaning with the frame mode. In 9-bit mode without parity it is the ninth transmit bit. With parity enabled it selects odd parity.

Top module: `uart_stat_irq`

## Requirements
- R1: After reset the status byte reads 0x20 (only transmit empty set). Both interrupt outputs are low, the receive data output is 0 and the transmit load pulse is low.
- R2: A received frame with no error sets status bit 7 (receive full) on the following edge. On that same edge it copies the frame data to the receive data output and the ninth/parity bit into the status bit 0 store.
- R3: A received frame with an overrun or framing error sets status bit 6 (error). It leaves bit 7, the receive data output and the bit 0 store unchanged.
- R4: A status read that saw bit 7 or bit 6 set, followed by a receive data read, clears that bit. A receive data read with no such earlier status read leaves both bits unchanged.
- R5: A flag that becomes set after the status read is not cleared by the data access that follows that read.
- R6: The receive interrupt output is high exactly when status bit 3 (receive enable) is 1 and bit 7 or bit 6 is 1.
- R7: The transmit interrupt output is high exactly when status bit 4 (transmit enable) is 1 and bit 5 (transmit empty) is 1.
- R8: A transmit data write that follows a status read which saw bit 5 set does two things. It clears bit 5, and on the next cycle it drives a one-cycle load pulse with the written byte. A write without such a read produces no pulse and leaves bit 5 unchanged.
- R9: A taken pulse from the transmitter sets bit 5 on the following edge.
- R10: Status writes change only bits 4, 3 and 1. Bits 7, 6, 5 are unaffected, and bit 2 always reads 0.
- R11: The ninth transmit output equals bit 1 only in 9-bit mode with parity disabled. The odd-parity select output equals bit 1 only with parity enabled. Bit 0 reads the stored received bit when 9-bit mode or parity is enabled, and reads 0 otherwise.
- R12: When a flag's set event and its armed clearing access fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| nine_bit_i | input | 1 | 9-bit frame mode selected |
| parity_en_i | input | 1 | Parity enabled |
| stat_rd_i | input | 1 | Processor reads the status byte this cycle |
| stat_wr_i | input | 1 | Processor writes the status byte this cycle |
| stat_wdata_i | input | 8 | Status write data |
| stat_rdata_o | output | 8 | Current status byte |
| rxd_rd_i | input | 1 | Processor reads the receive data register this cycle |
| rxd_o | output | DATA_W | Receive data register |
| txd_wr_i | input | 1 | Processor writes the transmit data register this cycle |
| txd_wdata_i | input | DATA_W | Transmit write data |
| txd_load_o | output | 1 | One-cycle pulse handing a byte to the transmitter |
| txd_o | output | DATA_W | Byte handed to the transmitter |
| tx_ninth_o | output | 1 | Ninth transmit bit |
| tx_par_odd_o | output | 1 | Odd parity select for the transmitter |
| rx_done_i | input | 1 | Receiver finished a frame |
| rx_data_i | input | DATA_W | Received frame data |
| rx_ninth_i | input | 1 | Received ninth bit or parity bit |
| rx_ovr_i | input | 1 | Overrun qualifier for rx_done_i |
| rx_ferr_i | input | 1 | Framing error qualifier for rx_done_i |
| tx_taken_i | input | 1 | Transmitter moved the buffered byte into its shift register |
| rx_irq_o | output | 1 | Receive interrupt request |
| tx_irq_o | output | 1 | Transmit interrupt request |

## Verification
The bench writes every value 0 to 255 into the status byte and checks all four mode combinations. This exposes a write that leaks into a flag, a bit 2 that is not zero, or a bit 1/bit 0 that ignores the mode. It clears flags in several ways: with an armed data access, with an unarmed one, and after a status read that came before the flag was set. A design that cleared a flag on a bare data access, or armed with a single shared bit, would drop data that software had not seen. An error frame is followed by a check of the receive data register, which catches a design that copies on errors. A set that collides with an armed clear catches the wrong priority, which would lose a frame. Armed and unarmed transmit writes expose a load pulse that fires at the wrong time or carries the wrong byte.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int unsigned STAT_W = 8;
  // status byte bit positions (software-visible layout)
  localparam int unsigned B_RXF = 7;
  localparam int unsigned B_ERR = 6;
  localparam int unsigned B_TXE = 5;
  localparam int unsigned B_TIE = 4;
  localparam int unsigned B_RIE = 3;
  localparam int unsigned B_TX9 = 1;
  localparam int unsigned B_RX9 = 0;
  // flag cell indices
  localparam int unsigned FI_RXF = 0;
  localparam int unsigned FI_ERR = 1;
  localparam int unsigned FI_TXE = 2;
  localparam int unsigned FLG_N  = 3;

  typedef struct packed {
    logic tie;
    logic rie;
    logic tx9;
  } ctrl_t;
endpackage

// File: rtl/uart_seq_flag.sv
module uart_seq_flag #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic snap_i,
  input  logic consume_i,
  output logic flag_o,
  output logic arm_o
);
  logic flag_q, arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= RST_VAL;
      arm_q  <= 1'b0;
    end else begin
      if (set_i)                  flag_q <= 1'b1;
      else if (consume_i && arm_q) flag_q <= 1'b0;
      if (snap_i)         arm_q <= flag_q;
      else if (consume_i) arm_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign arm_o  = arm_q;

  a_r4_armed_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume_i && arm_q && !set_i) |=> !flag_q);
  a_r5_unarmed_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume_i && !arm_q && !set_i) |=> $stable(flag_q));
  a_r12_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
endmodule

// File: rtl/uart_ctrl_reg.sv
module uart_ctrl_reg
  import uart_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [STAT_W-1:0] wdata_i,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_i) begin
      ctrl_q.tie <= wdata_i[B_TIE];
      ctrl_q.rie <= wdata_i[B_RIE];
      ctrl_q.tx9 <= wdata_i[B_TX9];
    end
  end

  assign ctrl_o = ctrl_q;

  a_r10_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ctrl_q));
endmodule

// File: rtl/uart_rx_data.sv
module uart_rx_data #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ninth_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ninth_o
);
  logic [DATA_W-1:0] data_q;
  logic              ninth_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      ninth_q <= 1'b0;
    end else if (load_i) begin
      data_q  <= data_i;
      ninth_q <= ninth_i;
    end
  end

  assign data_o  = data_q;
  assign ninth_o = ninth_q;

  a_r2_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (data_q == $past(data_i)) && (ninth_q == $past(ninth_i)));
endmodule

// File: rtl/uart_stat_irq.sv
module uart_stat_irq
  import uart_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nine_bit_i,
  input  logic              parity_en_i,
  input  logic              stat_rd_i,
  input  logic              stat_wr_i,
  input  logic [STAT_W-1:0] stat_wdata_i,
  output logic [STAT_W-1:0] stat_rdata_o,
  input  logic              rxd_rd_i,
  output logic [DATA_W-1:0] rxd_o,
  input  logic              txd_wr_i,
  input  logic [DATA_W-1:0] txd_wdata_i,
  output logic              txd_load_o,
  output logic [DATA_W-1:0] txd_o,
  output logic              tx_ninth_o,
  output logic              tx_par_odd_o,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_ninth_i,
  input  logic              rx_ovr_i,
  input  logic              rx_ferr_i,
  input  logic              tx_taken_i,
  output logic              rx_irq_o,
  output logic              tx_irq_o
);
  logic             rx_bad, rx_good;
  logic [FLG_N-1:0] set_v, cons_v, flag_v, arm_v;
  ctrl_t            ctrl;
  logic             rx9_q, tx_go;
  logic             load_q;
  logic [DATA_W-1:0] txd_q;

  assign rx_bad  = rx_done_i & (rx_ovr_i | rx_ferr_i);
  assign rx_good = rx_done_i & ~(rx_ovr_i | rx_ferr_i);

  assign set_v[FI_RXF]  = rx_good;
  assign set_v[FI_ERR]  = rx_bad;
  assign set_v[FI_TXE]  = tx_taken_i;
  assign cons_v[FI_RXF] = rxd_rd_i;
  assign cons_v[FI_ERR] = rxd_rd_i;
  assign cons_v[FI_TXE] = txd_wr_i;

  for (genvar g = 0; g < FLG_N; g++) begin : g_flag
    uart_seq_flag #(.RST_VAL(g == FI_TXE)) u_flag (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (set_v[g]),
      .snap_i    (stat_rd_i),
      .consume_i (cons_v[g]),
      .flag_o    (flag_v[g]),
      .arm_o     (arm_v[g])
    );
  end

  uart_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (stat_wr_i),
    .wdata_i (stat_wdata_i),
    .ctrl_o  (ctrl)
  );

  uart_rx_data #(.DATA_W(DATA_W)) u_rxd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (rx_good),
    .data_i  (rx_data_i),
    .ninth_i (rx_ninth_i),
    .data_o  (rxd_o),
    .ninth_o (rx9_q)
  );

  // byte goes to the transmitter only on an armed write
  assign tx_go = txd_wr_i & arm_v[FI_TXE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= 1'b0;
      txd_q  <= '0;
    end else begin
      load_q <= tx_go;
      if (tx_go) txd_q <= txd_wdata_i;
    end
  end

  always_comb begin
    stat_rdata_o        = '0;
    stat_rdata_o[B_RXF] = flag_v[FI_RXF];
    stat_rdata_o[B_ERR] = flag_v[FI_ERR];
    stat_rdata_o[B_TXE] = flag_v[FI_TXE];
    stat_rdata_o[B_TIE] = ctrl.tie;
    stat_rdata_o[B_RIE] = ctrl.rie;
    stat_rdata_o[B_TX9] = ctrl.tx9;
    stat_rdata_o[B_RX9] = rx9_q & (nine_bit_i | parity_en_i);
  end

  assign txd_load_o   = load_q;
  assign txd_o        = txd_q;
  assign tx_ninth_o   = ctrl.tx9 & nine_bit_i & ~parity_en_i;
  assign tx_par_odd_o = ctrl.tx9 & parity_en_i;
  assign rx_irq_o     = ctrl.rie & (flag_v[FI_RXF] | flag_v[FI_ERR]);
  assign tx_irq_o     = ctrl.tie & flag_v[FI_TXE];

  a_r3_err_keeps_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_bad |=> $stable(rxd_o));
  a_r8_load_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txd_load_o |-> $past(txd_wr_i));
  a_r8_load_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txd_load_o && !$past(txd_wr_i, 1)) |-> 1'b0);
  a_r9_taken_sets_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_taken_i |=> stat_rdata_o[B_TXE]);
  a_r2_good_sets_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_good |=> stat_rdata_o[B_RXF]);
endmodule

// File: tb/uart_stat_irq_tb.sv
`timescale 1ns/1ps
module uart_stat_irq_tb_top;
  localparam int unsigned DW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          nine_bit, parity_en;
  logic          stat_rd, stat_wr, rxd_rd, txd_wr;
  logic [7:0]    stat_wdata, stat_rdata;
  logic [DW-1:0] rxd, txd_wdata, txd, rx_data;
  logic          txd_load, tx_ninth, tx_par_odd;
  logic          rx_done, rx_ninth, rx_ovr, rx_ferr, tx_taken;
  logic          rx_irq, tx_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int cyc   = 0;

  always #2.5 clk_i = ~clk_i;

  uart_stat_irq #(.DATA_W(DW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .nine_bit_i(nine_bit), .parity_en_i(parity_en),
    .stat_rd_i(stat_rd), .stat_wr_i(stat_wr), .stat_wdata_i(stat_wdata),
    .stat_rdata_o(stat_rdata), .rxd_rd_i(rxd_rd), .rxd_o(rxd),
    .txd_wr_i(txd_wr), .txd_wdata_i(txd_wdata), .txd_load_o(txd_load), .txd_o(txd),
    .tx_ninth_o(tx_ninth), .tx_par_odd_o(tx_par_odd), .rx_done_i(rx_done),
    .rx_data_i(rx_data), .rx_ninth_i(rx_ninth), .rx_ovr_i(rx_ovr), .rx_ferr_i(rx_ferr),
    .tx_taken_i(tx_taken), .rx_irq_o(rx_irq), .tx_irq_o(tx_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr_stat(input logic [7:0] v);
    stat_wr = 1'b1; stat_wdata = v; tick(); stat_wr = 1'b0;
  endtask
  task automatic rd_stat();
    stat_rd = 1'b1; tick(); stat_rd = 1'b0;
  endtask
  task automatic rd_rxd();
    rxd_rd = 1'b1; tick(); rxd_rd = 1'b0;
  endtask
  task automatic wr_txd(input logic [7:0] d);
    txd_wr = 1'b1; txd_wdata = d; tick(); txd_wr = 1'b0;
  endtask
  task automatic frame(input logic [7:0] d, input logic n9, input logic ovr, input logic fe);
    rx_done = 1'b1; rx_data = d; rx_ninth = n9; rx_ovr = ovr; rx_ferr = fe;
    tick();
    rx_done = 1'b0; rx_ovr = 1'b0; rx_ferr = 1'b0;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    nine_bit = 0; parity_en = 0; stat_rd = 0; stat_wr = 0; stat_wdata = '0;
    rxd_rd = 0; txd_wr = 0; txd_wdata = '0; rx_done = 0; rx_data = '0;
    rx_ninth = 0; rx_ovr = 0; rx_ferr = 0; tx_taken = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 status", stat_rdata, 8'h20);
    chk("R1 rx_irq", rx_irq, 0);
    chk("R1 tx_irq", tx_irq, 0);
    chk("R1 rxd", rxd, 0);
    chk("R1 load", txd_load, 0);

    // R10/R7 sweep of all write values: only bits 4,3,1 stick
    for (int v = 0; v < 256; v++) begin
      wr_stat(8'(v));
      chk("R10 readback", stat_rdata, 8'h20 | (8'(v) & 8'h1A));
      chk("R7 tx_irq", tx_irq, (v >> 4) & 1);
      chk("R6 rx_irq idle", rx_irq, 0);
    end
    wr_stat(8'h10);

    // R8 armed write, R7 irq drops
    rd_stat();
    wr_txd(8'h96);
    chk("R8 empty cleared", stat_rdata[5], 0);
    chk("R8 load pulse", txd_load, 1);
    chk("R8 load data", txd, 8'h96);
    chk("R7 tx_irq low", tx_irq, 0);
    tick();
    chk("R8 pulse one cycle", txd_load, 0);
    // R8 unarmed write
    wr_txd(8'h11);
    chk("R8 unarmed no load", txd_load, 0);
    chk("R8 unarmed data kept", txd, 8'h96);
    // R5 tx: status read while empty=0, then taken, then write
    rd_stat();
    tx_taken = 1'b1; tick(); tx_taken = 1'b0;
    chk("R9 taken sets empty", stat_rdata[5], 1);
    chk("R7 tx_irq high", tx_irq, 1);
    wr_txd(8'h22);
    chk("R5 tx not cleared", stat_rdata[5], 1);
    chk("R5 tx no load", txd_load, 0);

    // R2 good frame in 9-bit mode, R6 irq
    nine_bit = 1;
    wr_stat(8'h08);
    chk("R6 no irq before frame", rx_irq, 0);
    frame(8'hA5, 1'b1, 1'b0, 1'b0);
    chk("R2 full set", stat_rdata[7], 1);
    chk("R2 data copied", rxd, 8'hA5);
    chk("R2 ninth bit", stat_rdata[0], 1);
    chk("R6 rx_irq full", rx_irq, 1);

    // R11 bit0 visibility and bit1 routing over modes
    for (int m = 0; m < 4; m++) begin
      nine_bit = m[0]; parity_en = m[1];
      @(negedge clk_i);
      chk("R11 bit0 view", stat_rdata[0], (m != 0) ? 1 : 0);
      for (int b = 0; b < 2; b++) begin
        wr_stat(8'(b << 1) | 8'h08);
        chk("R11 bit1 readback", stat_rdata[1], b);
        chk("R11 ninth out", tx_ninth, (m == 1) ? b : 0);
        chk("R11 parity out", tx_par_odd, m[1] ? b : 0);
      end
    end
    nine_bit = 1; parity_en = 0;
    wr_stat(8'h08);

    // R4 unarmed read keeps flag
    rd_rxd();
    chk("R4 unarmed keeps full", stat_rdata[7], 1);
    // R4 armed clear
    rd_stat();
    rd_rxd();
    chk("R4 armed clears full", stat_rdata[7], 0);
    chk("R6 rx_irq cleared", rx_irq, 0);

    // R5 flag set after status read survives
    rd_stat();
    frame(8'h5A, 1'b0, 1'b0, 1'b0);
    rd_rxd();
    chk("R5 late flag kept", stat_rdata[7], 1);
    chk("R2 second data", rxd, 8'h5A);
    chk("R2 ninth cleared", stat_rdata[0], 0);
    rd_stat();
    rd_rxd();
    chk("R4 clear after late", stat_rdata[7], 0);

    // R3 overrun frame
    frame(8'h3C, 1'b1, 1'b1, 1'b0);
    chk("R3 err set", stat_rdata[6], 1);
    chk("R3 full not set", stat_rdata[7], 0);
    chk("R3 data kept", rxd, 8'h5A);
    chk("R3 ninth kept", stat_rdata[0], 0);
    chk("R6 rx_irq on err", rx_irq, 1);
    rd_stat();
    rd_rxd();
    chk("R4 err cleared", stat_rdata[6], 0);
    // R3 framing error
    frame(8'hC3, 1'b1, 1'b0, 1'b1);
    chk("R3 ferr sets err", stat_rdata[6], 1);
    chk("R3 ferr data kept", rxd, 8'h5A);
    wr_stat(8'h00);
    chk("R6 rx_irq disabled", rx_irq, 0);
    chk("R10 write keeps err", stat_rdata[6], 1);
    rd_stat();
    rd_rxd();
    chk("R4 ferr cleared", stat_rdata[6], 0);

    // R12 set collides with armed clear
    frame(8'h77, 1'b0, 1'b0, 1'b0);
    rd_stat();
    rxd_rd = 1'b1; rx_done = 1'b1; rx_data = 8'h88; rx_ninth = 1'b1;
    tick();
    rxd_rd = 1'b0; rx_done = 1'b0;
    chk("R12 set wins", stat_rdata[7], 1);
    chk("R12 new data", rxd, 8'h88);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule